// File: doc/BRIEF.md
# Internal Data-Move Unit

This block carries out the byte-transfer operations of an 8051-class core that stay inside on-chip data memory. It covers loads into and stores from the accumulator, memory-to-memory copies and the 16-bit data-pointer load. It also covers stack push and pop and the two exchange forms: whole byte and low nibble. The core supplies an already decoded operation kind, an addressing mode for each operand, two operand addresses and a 16-bit immediate. It then raises `start` for one cycle.

The unit holds a 256-byte data RAM. It also holds the special-function registers it needs: accumulator, stack pointer, both data-pointer halves and the status word. It decides for each access whether it lands in lower RAM, upper RAM or the register file. It reports the end of each operation with a one-cycle `done`.

Top module: `dmove_unit`

## Requirements
- R1: While and after reset, `spOut` is 0x07, `accOut`, `dptrOut` and `pswOut` are zero, and `busy` and `done` are low.
- R2: `start` is accepted only when `busy` is low. `busy` is high for the two cycles after the accepting edge. `done` is high for exactly one cycle, starting at the second edge after the accepting edge, and `busy` is low at that same time. A `start` raised while `busy` is high has no effect.
- R3: In direct mode (code 0), an address below 0x80 selects lower RAM. An address of 0x80 or above selects the register file: accumulator 0xE0, stack pointer 0x81, pointer low 0x82, pointer high 0x83, status 0xD0. Any other register address reads as zero and ignores writes.
- R4: In indirect mode (code 1), the byte in register R0 or R1 (chosen by address bit 0) is used as a RAM address over all 256 bytes. Addresses 0x80 and above reach upper RAM and never the register file.
- R5: In register mode (code 2), Rn (address bits 2:0) lives at RAM address bank×8+n. The bank is status bits 4:3, and R0/R1 used as pointers follow the same bank.
- R6: In immediate mode (code 3), a source yields the immediate's low byte. A destination given in this mode is left unwritten.
- R7: Kind 0 loads the source byte into the accumulator. Kind 1 stores the accumulator to the destination.
- R8: Kind 2 copies the source byte to the destination and leaves the accumulator unchanged.
- R9: Kind 3 loads the immediate into the data pointer, bits 15:8 to the high half and bits 7:0 to the low half.
- R10: Kind 4 (push) first adds one to the stack pointer. It then writes the byte at the direct source address into RAM at the new stack pointer, even when that pointer is 0x80 or above.
- R11: Kind 5 (pop) reads RAM at the stack pointer into the direct destination, then subtracts one from the stack pointer.
- R12: The stack pointer wraps from 0xFF to 0x00 on push and from 0x00 to 0xFF on pop.
- R13: Kind 6 swaps the accumulator with the source byte, given in direct, indirect or register mode.
- R14: Kind 7 swaps bits 3:0 of the accumulator with bits 3:0 of the RAM byte pointed to by R0/R1 (source address bit 0). Bits 7:4 of both stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| opKind | input | 3 | Operation kind, codes 0..7 as in R7..R14 |
| srcMode | input | 2 | Source addressing mode code |
| dstMode | input | 2 | Destination addressing mode code |
| srcAddr | input | 8 | Source address, register number or pointer select |
| dstAddr | input | 8 | Destination address, register number or pointer select |
| imm | input | 16 | Immediate value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| accOut | output | 8 | Accumulator |
| spOut | output | 8 | Stack pointer |
| dptrOut | output | 16 | Data pointer |
| pswOut | output | 8 | Status word |

## Verification
Wrong routing of the 0x80..0xFF range shows up at the first read-back after a write. A direct read that should give zero returns upper-RAM content, or an indirect read comes back from the accumulator or pointer. Stack-pointer slips appear on `spOut` as soon as the push or pop completes. Misplaced stack bytes, bank errors and nibble errors in the exchange appear in the accumulator one operation later, when the location is loaded back. A control fault shows as `done` arriving a cycle early or late, or as a second operation being taken while `busy` is high.

// File: rtl/dmove_pkg.sv
package dmove_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [7:0] SFR_ACC = 8'hE0;
  localparam logic [7:0] SFR_SP  = 8'h81;
  localparam logic [7:0] SFR_DPL = 8'h82;
  localparam logic [7:0] SFR_DPH = 8'h83;
  localparam logic [7:0] SFR_PSW = 8'hD0;

  typedef enum logic [2:0] {
    OP_LD_ACC, OP_ST_ACC, OP_MOVE, OP_LD_DPTR,
    OP_PUSH, OP_POP, OP_XCH, OP_XCHD
  } opKind_e;

  typedef enum logic [1:0] {AM_DIR, AM_IND, AM_REG, AM_IMM} amode_e;
  typedef enum logic [1:0] {RD_SRC, RD_STACK, RD_ACC} rdSel_e;
  typedef enum logic [1:0] {WT_NONE, WT_DST, WT_SRC, WT_STACK} wrTgt_e;
  typedef enum logic [1:0] {WD_TMP, WD_ACC, WD_NIBBLE} wrData_e;

  typedef struct packed {
    logic    capture;
    logic    latchTmp;
    rdSel_e  rdSel;
    logic    spInc;
    logic    spDec;
    wrTgt_e  wrTgt;
    wrData_e wrData;
    logic    accLoad;
    logic    accNibble;
    logic    dptrLoad;
    amode_e  srcMode;
    amode_e  dstMode;
  } strobe_t;
endpackage

// File: rtl/dmove_ea.sv
module dmove_ea
  import dmove_pkg::*;
(
  input  amode_e      mode,
  input  logic [7:0]  addr,
  input  logic [1:0]  bank,
  input  logic [7:0]  ptrData,
  output logic [7:0]  ptrAddr,
  output logic [7:0]  ea,
  output logic        isSfr,
  output logic        canWrite
);
  // R5: working registers sit at bank*8+n
  assign ptrAddr = {3'b000, bank, 2'b00, addr[0]};

  always_comb begin
    unique case (mode)
      AM_DIR:  ea = addr;
      AM_IND:  ea = ptrData;
      AM_REG:  ea = {3'b000, bank, addr[2:0]};
      default: ea = addr;
    endcase
  end

  // R3/R4: only direct mode reaches the register file
  assign isSfr    = (mode == AM_DIR) && addr[7];
  assign canWrite = (mode != AM_IMM);
endmodule

// File: rtl/dmove_ctrl.sv
module dmove_ctrl
  import dmove_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opIn,
  input  logic [1:0] srcModeIn,
  input  logic [1:0] dstModeIn,
  output strobe_t    stb,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;

  state_e  state;
  opKind_e opQ;
  amode_e  srcModeQ, dstModeQ;
  logic    accept;

  assign accept = (state == ST_IDLE) && start;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opQ      <= OP_LD_ACC;
      srcModeQ <= AM_DIR;
      dstModeQ <= AM_DIR;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_WRITE);
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_READ;
          opQ      <= opKind_e'(opIn);
          srcModeQ <= amode_e'(srcModeIn);
          dstModeQ <= amode_e'(dstModeIn);
        end
        ST_READ:  state <= ST_WRITE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.capture = accept;
    // R10/R11: stack operands are direct; R14: exchange-digit is indirect
    stb.srcMode = (opQ == OP_PUSH) ? AM_DIR :
                  (opQ == OP_XCHD) ? AM_IND : srcModeQ;
    stb.dstMode = (opQ == OP_POP) ? AM_DIR : dstModeQ;
    if (state == ST_READ) begin
      unique case (opQ)
        OP_ST_ACC: begin stb.latchTmp = 1'b1; stb.rdSel = RD_ACC; end
        OP_POP:    begin stb.latchTmp = 1'b1; stb.rdSel = RD_STACK; stb.spDec = 1'b1; end
        OP_PUSH:   begin stb.latchTmp = 1'b1; stb.rdSel = RD_SRC; stb.spInc = 1'b1; end
        OP_LD_DPTR: ;
        default:   begin stb.latchTmp = 1'b1; stb.rdSel = RD_SRC; end
      endcase
    end else if (state == ST_WRITE) begin
      unique case (opQ)
        OP_LD_ACC:  stb.accLoad = 1'b1;
        OP_LD_DPTR: stb.dptrLoad = 1'b1;
        OP_PUSH:    begin stb.wrTgt = WT_STACK; stb.wrData = WD_TMP; end
        OP_XCH:     begin stb.wrTgt = WT_SRC; stb.wrData = WD_ACC; stb.accLoad = 1'b1; end
        OP_XCHD:    begin
          stb.wrTgt = WT_SRC; stb.wrData = WD_NIBBLE;
          stb.accLoad = 1'b1; stb.accNibble = 1'b1;
        end
        default:    begin stb.wrTgt = WT_DST; stb.wrData = WD_TMP; end
      endcase
    end
  end

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busy && !done));
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/dmove_dpath.sv
module dmove_dpath
  import dmove_pkg::*;
#(
  parameter logic [7:0] SP_INIT = 8'h07
)(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [7:0]    srcAddrIn,
  input  logic [7:0]    dstAddrIn,
  input  logic [15:0]   immIn,
  output logic [7:0]    accOut,
  output logic [7:0]    spOut,
  output logic [15:0]   dptrOut,
  output logic [7:0]    pswOut
);
  localparam int RAM_DEPTH = 1 << ADDR_W;
  localparam int N_OPND    = 2;

  logic [DATA_W-1:0] ram [RAM_DEPTH];
  logic [7:0]  acc, sp, dpl, dph, psw, tmp;
  logic [7:0]  srcAddrQ, dstAddrQ;
  logic [15:0] immQ;

  amode_e     opMode  [N_OPND];
  logic [7:0] opAddr  [N_OPND];
  logic [7:0] ptrAddr [N_OPND];
  logic [7:0] ea      [N_OPND];
  logic       isSfr   [N_OPND];
  logic       canWr   [N_OPND];

  assign opMode[0] = stb.srcMode;
  assign opMode[1] = stb.dstMode;
  assign opAddr[0] = srcAddrQ;
  assign opAddr[1] = dstAddrQ;

  // index 0 resolves the source operand, index 1 the destination
  for (genvar g = 0; g < N_OPND; g++) begin : gEa
    dmove_ea uEa (
      .mode    (opMode[g]),
      .addr    (opAddr[g]),
      .bank    (psw[4:3]),
      .ptrData (ram[ptrAddr[g]]),
      .ptrAddr (ptrAddr[g]),
      .ea      (ea[g]),
      .isSfr   (isSfr[g]),
      .canWrite(canWr[g])
    );
  end

  function automatic logic [7:0] sfrPick(input logic [7:0] a, input logic [7:0] vAcc,
      input logic [7:0] vSp, input logic [7:0] vDpl, input logic [7:0] vDph,
      input logic [7:0] vPsw);
    unique case (a)
      SFR_ACC: return vAcc;
      SFR_SP:  return vSp;
      SFR_DPL: return vDpl;
      SFR_DPH: return vDph;
      SFR_PSW: return vPsw;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] srcVal, rdVal, wrAddr, wrVal;
  logic       wrEn, wrIsSfr, sfrWr;

  always_comb begin
    if (stb.srcMode == AM_IMM)  srcVal = immQ[7:0];
    else if (isSfr[0])          srcVal = sfrPick(ea[0], acc, sp, dpl, dph, psw);
    else                        srcVal = ram[ea[0]];
    unique case (stb.rdSel)
      RD_STACK: rdVal = ram[sp];
      RD_ACC:   rdVal = acc;
      default:  rdVal = srcVal;
    endcase
  end

  always_comb begin
    wrAddr = ea[1]; wrIsSfr = isSfr[1]; wrEn = 1'b0;
    unique case (stb.wrTgt)
      WT_DST:   wrEn = canWr[1];
      WT_SRC:   begin wrAddr = ea[0]; wrIsSfr = isSfr[0]; wrEn = canWr[0]; end
      WT_STACK: begin wrAddr = sp; wrIsSfr = 1'b0; wrEn = 1'b1; end
      default:  wrEn = 1'b0;
    endcase
    unique case (stb.wrData)
      WD_ACC:    wrVal = acc;
      WD_NIBBLE: wrVal = {tmp[7:4], acc[3:0]};
      default:   wrVal = tmp;
    endcase
  end

  assign sfrWr = wrEn && wrIsSfr;

  always_ff @(posedge clk) begin
    if (wrEn && !wrIsSfr) ram[wrAddr] <= wrVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0; sp <= SP_INIT; dpl <= '0; dph <= '0; psw <= '0; tmp <= '0;
      srcAddrQ <= '0; dstAddrQ <= '0; immQ <= '0;
    end else begin
      if (stb.capture) begin
        srcAddrQ <= srcAddrIn; dstAddrQ <= dstAddrIn; immQ <= immIn;
      end
      if (stb.latchTmp) tmp <= rdVal;
      if (stb.accLoad)                       acc <= stb.accNibble ? {acc[7:4], tmp[3:0]} : tmp;
      else if (sfrWr && wrAddr == SFR_ACC)   acc <= wrVal;
      // R12: plain 8-bit arithmetic wraps both ways
      if (stb.spInc)                         sp <= sp + 8'd1;
      else if (stb.spDec)                    sp <= sp - 8'd1;
      else if (sfrWr && wrAddr == SFR_SP)    sp <= wrVal;
      if (stb.dptrLoad) begin
        dph <= immQ[15:8]; dpl <= immQ[7:0];
      end else begin
        if (sfrWr && wrAddr == SFR_DPL) dpl <= wrVal;
        if (sfrWr && wrAddr == SFR_DPH) dph <= wrVal;
      end
      if (sfrWr && wrAddr == SFR_PSW) psw <= wrVal;
    end
  end

  assign accOut  = acc;
  assign spOut   = sp;
  assign dptrOut = {dph, dpl};
  assign pswOut  = psw;

  assert_sp_inc_wrap_R12: assert property (@(posedge clk) disable iff (!rstN)
    stb.spInc |=> sp == $past(sp) + 8'd1);
  assert_sp_dec_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.spDec |=> sp == $past(sp) - 8'd1);
  assert_xchd_high_kept_R14: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accLoad && stb.accNibble) |=> acc[7:4] == $past(acc[7:4]));
  assert_stack_not_sfr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrTgt == WT_STACK) |=> $stable(psw) && $stable(dpl) && $stable(dph));
endmodule

// File: rtl/dmove_unit.sv
module dmove_unit
  import dmove_pkg::*;
#(
  parameter logic [7:0] SP_RESET = 8'h07
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  opKind,
  input  logic [1:0]  srcMode,
  input  logic [1:0]  dstMode,
  input  logic [7:0]  srcAddr,
  input  logic [7:0]  dstAddr,
  input  logic [15:0] imm,
  output logic        busy,
  output logic        done,
  output logic [7:0]  accOut,
  output logic [7:0]  spOut,
  output logic [15:0] dptrOut,
  output logic [7:0]  pswOut
);
  strobe_t stb;

  dmove_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opKind),
    .srcModeIn(srcMode), .dstModeIn(dstMode),
    .stb(stb), .busy(busy), .done(done)
  );

  dmove_dpath #(.SP_INIT(SP_RESET)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .srcAddrIn(srcAddr), .dstAddrIn(dstAddr), .immIn(imm),
    .accOut(accOut), .spOut(spOut), .dptrOut(dptrOut), .pswOut(pswOut)
  );
endmodule

// File: tb/dmove_unit_tb.sv
module dmove_unit_tb_top;
  localparam logic [2:0] K_LDA = 3'd0, K_STA = 3'd1, K_MOV = 3'd2, K_DPTR = 3'd3,
                         K_PUSH = 3'd4, K_POP = 3'd5, K_XCH = 3'd6, K_XCHD = 3'd7;
  localparam logic [1:0] M_DIR = 2'd0, M_IND = 2'd1, M_REG = 2'd2, M_IMM = 2'd3;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [2:0] opKind = '0;
  logic [1:0] srcMode = '0, dstMode = '0;
  logic [7:0] srcAddr = '0, dstAddr = '0;
  logic [15:0] imm = '0;
  logic busy, done;
  logic [7:0] accOut, spOut, pswOut;
  logic [15:0] dptrOut;
  int nTests = 0, nFail = 0;

  always #5 clk = ~clk;

  dmove_unit dut_i (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] k, input logic [1:0] sm, input logic [1:0] dm,
                      input logic [7:0] sa, input logic [7:0] da, input logic [15:0] im);
    int w;
    opKind = k; srcMode = sm; dstMode = dm; srcAddr = sa; dstAddr = da; imm = im;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (done !== 1'b1 && w < 20) begin
      @(negedge clk);
      w++;
    end
    if (w >= 20) chk("R2 op timeout", 16'd0, 16'd1);
  endtask

  task automatic setDir(input logic [7:0] a, input logic [7:0] v);
    doOp(K_MOV, M_IMM, M_DIR, 8'h00, a, {8'h00, v});
  endtask

  task automatic loadA(input logic [7:0] v);
    doOp(K_LDA, M_IMM, M_DIR, 8'h00, 8'h00, {8'h00, v});
  endtask

  task automatic readDir(input logic [7:0] a, output logic [7:0] v);
    doOp(K_LDA, M_DIR, M_DIR, a, 8'h00, 16'h0);
    v = accOut;
  endtask

  task automatic readInd(input logic [7:0] a, output logic [7:0] v);
    setDir(8'h00, a);
    doOp(K_LDA, M_IND, M_DIR, 8'h00, 8'h00, 16'h0);
    v = accOut;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sp", {8'h0, spOut}, 16'h0007);
    chk("R1 acc", {8'h0, accOut}, 16'h0);
    chk("R1 dptr", dptrOut, 16'h0);
    chk("R1 psw", {8'h0, pswOut}, 16'h0);
    chk("R1 busy/done", {14'h0, busy, done}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 exact timing and ignored start while busy; R9 pointer load
    opKind = K_DPTR; imm = 16'h1234; start = 1'b1;
    @(negedge clk);
    opKind = K_DPTR; imm = 16'hBEEF;
    chk("R2 phase1", {14'h0, busy, done}, 16'h2);
    @(negedge clk);
    start = 1'b0;
    chk("R2 phase2", {14'h0, busy, done}, 16'h2);
    @(negedge clk);
    chk("R2 done", {14'h0, busy, done}, 16'h1);
    chk("R9 dptr", dptrOut, 16'h1234);
    @(negedge clk);
    chk("R2 done single", {14'h0, busy, done}, 16'h0);
    chk("R2 start ignored", dptrOut, 16'h1234);

    // R5 register banks
    for (int b = 0; b < 4; b++) begin
      setDir(8'hD0, 8'(b << 3));
      chk("R3 psw write", {8'h0, pswOut}, 16'(b << 3));
      for (int n = 2; n < 8; n++) begin
        doOp(K_MOV, M_IMM, M_REG, 8'h00, 8'(n), 16'(8'h40 + b * 8 + n));
        readDir(8'(b * 8 + n), v);
        chk("R5 bank write", {8'h0, v}, 16'(8'h40 + b * 8 + n));
        doOp(K_LDA, M_REG, M_DIR, 8'(n), 8'h00, 16'h0);
        chk("R5 bank read", {8'h0, accOut}, 16'(8'h40 + b * 8 + n));
      end
    end
    setDir(8'hD0, 8'h00);

    // R3 lower RAM sweep through direct mode
    for (int a = 8'h08; a < 8'h80; a++) setDir(8'(a), 8'(a) ^ 8'h5A);
    for (int a = 8'h08; a < 8'h80; a++) begin
      readDir(8'(a), v);
      chk("R3 lower", {8'h0, v}, {8'h0, 8'(a) ^ 8'h5A});
    end
    // R4 upper RAM sweep through indirect mode
    for (int a = 8'h80; a < 9'h100; a++) begin
      setDir(8'h00, 8'(a));
      doOp(K_MOV, M_IMM, M_IND, 8'h00, 8'h00, {8'h00, 8'(a) ^ 8'hC3});
    end
    for (int a = 8'h80; a < 9'h100; a++) begin
      readInd(8'(a), v);
      chk("R4 upper", {8'h0, v}, {8'h0, 8'(a) ^ 8'hC3});
    end
    setDir(8'h01, 8'h40);
    doOp(K_LDA, M_IND, M_DIR, 8'h01, 8'h00, 16'h0);
    chk("R4 via R1", {8'h0, accOut}, 16'h001A);
    // R3 unmapped register address reads zero, write ignored
    readDir(8'h90, v);
    chk("R3 unmapped read", {8'h0, v}, 16'h0);
    setDir(8'h90, 8'h77);
    readDir(8'h90, v);
    chk("R3 unmapped write", {8'h0, v}, 16'h0);
    readInd(8'h90, v);
    chk("R4 upper untouched", {8'h0, v}, 16'h0053);

    // R7 store accumulator, R6 immediate
    loadA(8'h77);
    chk("R6 R7 load imm", {8'h0, accOut}, 16'h0077);
    doOp(K_STA, M_DIR, M_DIR, 8'h00, 8'h60, 16'h0);
    readDir(8'h60, v);
    chk("R7 store", {8'h0, v}, 16'h0077);
    loadA(8'h9A);
    doOp(K_STA, M_DIR, M_DIR, 8'h00, 8'h83, 16'h0);
    chk("R7 store sfr", dptrOut, 16'h9A34);
    loadA(8'h11);
    doOp(K_STA, M_DIR, M_IMM, 8'h00, 8'h50, 16'h0);
    readDir(8'h50, v);
    chk("R6 imm dest no write", {8'h0, v}, 16'h000A);

    // R8 memory copy keeps accumulator
    loadA(8'h11);
    doOp(K_MOV, M_DIR, M_DIR, 8'h60, 8'h61, 16'h0);
    chk("R8 acc kept", {8'h0, accOut}, 16'h0011);
    readDir(8'h61, v);
    chk("R8 copy", {8'h0, v}, 16'h0077);

    // R9 pointer halves readable as registers
    doOp(K_DPTR, M_DIR, M_DIR, 8'h00, 8'h00, 16'hC0DE);
    chk("R9 load", dptrOut, 16'hC0DE);
    readDir(8'h82, v);
    chk("R9 low", {8'h0, v}, 16'h00DE);
    readDir(8'h83, v);
    chk("R9 high", {8'h0, v}, 16'h00C0);

    // R10 push
    setDir(8'h20, 8'h5E);
    doOp(K_PUSH, M_IMM, M_DIR, 8'h20, 8'h00, 16'h0);
    chk("R10 sp", {8'h0, spOut}, 16'h0008);
    readDir(8'h08, v);
    chk("R10 data", {8'h0, v}, 16'h005E);
    doOp(K_PUSH, M_DIR, M_DIR, 8'h82, 8'h00, 16'h0);
    readDir(8'h09, v);
    chk("R10 push sfr", {8'h0, v}, 16'h00DE);
    // R12 wrap upward through upper RAM
    setDir(8'h81, 8'hFE);
    setDir(8'h21, 8'hAB);
    doOp(K_PUSH, M_DIR, M_DIR, 8'h21, 8'h00, 16'h0);
    chk("R10 sp upper", {8'h0, spOut}, 16'h00FF);
    doOp(K_PUSH, M_DIR, M_DIR, 8'h20, 8'h00, 16'h0);
    chk("R12 inc wrap", {8'h0, spOut}, 16'h0000);
    readDir(8'h00, v);
    chk("R12 data at 0", {8'h0, v}, 16'h005E);
    // R11 pop and R12 wrap downward
    doOp(K_POP, M_DIR, M_DIR, 8'h00, 8'h30, 16'h0);
    chk("R12 dec wrap", {8'h0, spOut}, 16'h00FF);
    readDir(8'h30, v);
    chk("R11 pop0", {8'h0, v}, 16'h005E);
    doOp(K_POP, M_DIR, M_DIR, 8'h00, 8'h31, 16'h0);
    chk("R11 sp", {8'h0, spOut}, 16'h00FE);
    readDir(8'h31, v);
    chk("R11 pop upper", {8'h0, v}, 16'h00AB);
    setDir(8'h81, 8'h09);
    doOp(K_POP, M_DIR, M_DIR, 8'h00, 8'h83, 16'h0);
    chk("R11 pop sfr", dptrOut, 16'hDEDE);
    chk("R11 sp2", {8'h0, spOut}, 16'h0008);
    // R10 stack at 0x81 stays in RAM
    setDir(8'h81, 8'h80);
    doOp(K_PUSH, M_DIR, M_DIR, 8'h20, 8'h00, 16'h0);
    chk("R10 stack not sfr", {8'h0, spOut}, 16'h0081);
    readInd(8'h81, v);
    chk("R10 stack in upper RAM", {8'h0, v}, 16'h005E);

    // R13 exchange in three modes
    setDir(8'h40, 8'hA5);
    loadA(8'h3C);
    doOp(K_XCH, M_DIR, M_DIR, 8'h40, 8'h00, 16'h0);
    chk("R13 dir acc", {8'h0, accOut}, 16'h00A5);
    readDir(8'h40, v);
    chk("R13 dir mem", {8'h0, v}, 16'h003C);
    setDir(8'h02, 8'h12);
    loadA(8'h34);
    doOp(K_XCH, M_REG, M_DIR, 8'h02, 8'h00, 16'h0);
    chk("R13 reg acc", {8'h0, accOut}, 16'h0012);
    readDir(8'h02, v);
    chk("R13 reg mem", {8'h0, v}, 16'h0034);
    setDir(8'h01, 8'h90);
    loadA(8'h66);
    doOp(K_XCH, M_IND, M_DIR, 8'h01, 8'h00, 16'h0);
    chk("R13 ind acc", {8'h0, accOut}, 16'h0053);
    readInd(8'h90, v);
    chk("R13 ind mem", {8'h0, v}, 16'h0066);

    // R14 low-nibble exchange, all nibble values, through R0 and R1
    for (int n = 0; n < 16; n++) begin
      setDir(8'h00, 8'h45);
      setDir(8'h45, {4'hC, 4'(15 - n)});
      loadA({4'h7, 4'(n)});
      doOp(K_XCHD, M_DIR, M_DIR, 8'h00, 8'h00, 16'h0);
      chk("R14 acc", {8'h0, accOut}, {8'h0, 4'h7, 4'(15 - n)});
      readDir(8'h45, v);
      chk("R14 mem", {8'h0, v}, {8'h0, 4'hC, 4'(n)});
    end
    setDir(8'h01, 8'hC0);
    doOp(K_MOV, M_IMM, M_IND, 8'h00, 8'h01, 16'h009F);
    loadA(8'h62);
    doOp(K_XCHD, M_DIR, M_DIR, 8'h01, 8'h00, 16'h0);
    chk("R14 via R1 acc", {8'h0, accOut}, 16'h006F);
    readInd(8'hC0, v);
    chk("R14 via R1 mem", {8'h0, v}, 16'h0092);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule